// File: doc/BRIEF.md
# Configurable GPIO Port Controller

A 16-pin general-purpose I/O port with a simple word-addressed register interface. Every pin owns a 4-bit configuration field that picks one of several pin personalities: an analog input, a floating digital input, a weakly pulled input, or an output. An output is push-pull or open-drain and takes its value either from the output data register or from an alternate-function source inside the chip. The block turns each field into pad controls (output enable, output value, pull-up, pull-down, analog enable and a 2-bit slew code) and samples the pad inputs into an input data register on every clock.

Software changes outputs with either a plain write to the output data register or a write to a set/clear register. The set/clear register updates any group of output bits in one bus write, with no read-modify-write. The reset value of every configuration field and every output data bit is a parameter. This lets a few pins leave reset as pulled inputs while the rest are floating inputs.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, the configuration fields equal the parameter RST_CFG and the output data register equals RST_ODR. By default every pin is a floating input (field 4'b0100), except pins 4, 13 and 15, which are pulled up, and pin 14, which is pulled down (field 4'b1000). With the defaults, no pad is driven and analog enable is 0 on every pin.
- R2: Field bits [1:0] are the mode and bits [3:2] are the config. Mode 00 with config 00 is analog: analog enable is 1, output enable and both pulls are 0, and the pin's input data bit reads 0.
- R3: Mode 00 with config 01 (or 11) is a floating input: output enable, both pulls and analog enable are 0.
- R4: Mode 00 with config 10 is a pulled input. The pull-up is enabled when the pin's output data bit is 1 and the pull-down when it is 0. The two pulls are never on together.
- R5: A non-zero mode is an output. Config bit 3 = 0 takes the value from the output data bit. Config bit 2 = 0 is push-pull: output enable is 1 and the pad value equals the selected value.
- R6: Config bit 3 = 1 takes the output value from af_out_i for that pin.
- R7: Config bit 2 = 1 is open-drain: the pad value is always 0 and output enable is the inverse of the selected value.
- R8: pad_slew_o[2i+1:2i] equals the mode for output pins and 00 for input pins.
- R9: The input data register (address 2) takes pad_in_i masked by the non-analog pins on every clock and is readable on the next cycle. Bus writes to it have no effect.
- R10: A write to address 4 sets the output data bits that are 1 in wdata[15:0] and clears those that are 1 in wdata[31:16]. When both are 1 for a pin, set wins. The register reads as zero.
- R11: Address 0 holds the fields of pins 0-7 and address 1 those of pins 8-15, with pin n at bits [4(n mod 8)+3:4(n mod 8)]. Address 3 is the output data register in bits [15:0]. Its upper bits are ignored on write and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| af_out_i | input | 16 | Alternate-function output values |
| pad_in_i | input | 16 | Pad input levels |
| pad_oe_o | output | 16 | Pad output enable |
| pad_out_o | output | 16 | Pad output value |
| pad_pu_o | output | 16 | Weak pull-up enable |
| pad_pd_o | output | 16 | Weak pull-down enable |
| pad_ana_o | output | 16 | Analog enable |
| pad_slew_o | output | 32 | Per-pin slew code, 2 bits per pin |

## Verification
The bench builds the port with its default parameters: 16 pins, a 32-bit data word, and the default reset fields and output data. These defaults put four pulled pins in the reset state, so the pulled-input decode and both pull directions can be checked before any write. Because both configuration words are populated, every personality can be placed on pins in each half of the port. This covers analog masking of the input data, open-drain release, alternate-function values and the set-over-clear priority of the set/clear register.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef struct packed {
    logic       oe;
    logic       out;
    logic       pu;
    logic       pd;
    logic       ana;
    logic [1:0] slew;
    logic       in_en;
  } pad_ctl_t;

  localparam int unsigned FIELD_W = 4;
endpackage

// File: rtl/gpio_pin_decode.sv
module gpio_pin_decode
  import gpio_pkg::*;
(
  input  logic [FIELD_W-1:0] field_i,
  input  logic               odr_bit_i,
  input  logic               af_bit_i,
  output pad_ctl_t           ctl_o
);
  logic [1:0] mode, cnf;
  logic       val;

  assign mode = field_i[1:0];
  assign cnf  = field_i[3:2];
  assign val  = cnf[1] ? af_bit_i : odr_bit_i;

  always_comb begin
    ctl_o = '0;
    ctl_o.in_en = 1'b1;
    if (mode == 2'b00) begin
      unique case (cnf)
        2'b00: begin
          ctl_o.ana   = 1'b1;
          ctl_o.in_en = 1'b0;
        end
        2'b10: begin
          ctl_o.pu = odr_bit_i;
          ctl_o.pd = ~odr_bit_i;
        end
        default: ;
      endcase
    end else begin
      ctl_o.slew = mode;
      if (cnf[0]) begin
        // open-drain: sink low only
        ctl_o.oe  = ~val;
        ctl_o.out = 1'b0;
      end else begin
        ctl_o.oe  = 1'b1;
        ctl_o.out = val;
      end
    end
  end
endmodule

// File: rtl/gpio_in_sample.sv
module gpio_in_sample #(
  parameter int unsigned NUM_PINS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pad_in_i,
  input  logic [NUM_PINS-1:0] in_en_i,
  output logic [NUM_PINS-1:0] idr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idr_o <= '0;
    else         idr_o <= pad_in_i & in_en_i;
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int unsigned           NUM_PINS = 16,
  parameter int unsigned           DATA_W   = 32,
  parameter int unsigned           ADDR_W   = 3,
  parameter logic [NUM_PINS*4-1:0] RST_CFG  = '0,
  parameter logic [NUM_PINS-1:0]   RST_ODR  = '0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [NUM_PINS-1:0]   idr_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [NUM_PINS*4-1:0] cfg_o,
  output logic [NUM_PINS-1:0]   odr_o
);
  localparam int unsigned CFG_W = NUM_PINS * 4;
  localparam int unsigned NCW   = CFG_W / DATA_W;
  localparam logic [ADDR_W-1:0] IDR_A = ADDR_W'(NCW);
  localparam logic [ADDR_W-1:0] ODR_A = ADDR_W'(NCW + 1);
  localparam logic [ADDR_W-1:0] BSR_A = ADDR_W'(NCW + 2);

  logic                wr;
  logic [NUM_PINS-1:0] set_v, clr_v;

  assign wr    = req_i & we_i;
  assign set_v = wdata_i[NUM_PINS-1:0];
  assign clr_v = wdata_i[2*NUM_PINS-1:NUM_PINS];

  for (genvar w = 0; w < NCW; w++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cfg_o[w*DATA_W +: DATA_W] <= RST_CFG[w*DATA_W +: DATA_W];
      else if (wr && addr_i == ADDR_W'(w))
        cfg_o[w*DATA_W +: DATA_W] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    odr_o <= RST_ODR;
    else if (wr && addr_i == ODR_A) odr_o <= set_v;
    else if (wr && addr_i == BSR_A) odr_o <= (odr_o & ~clr_v) | set_v; // set wins
  end

  always_comb begin
    rdata_o = '0;
    for (int w = 0; w < NCW; w++)
      if (addr_i == ADDR_W'(w)) rdata_o = cfg_o[w*DATA_W +: DATA_W];
    if (addr_i == IDR_A) rdata_o[NUM_PINS-1:0] = idr_i;
    if (addr_i == ODR_A) rdata_o[NUM_PINS-1:0] = odr_o;
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned           NUM_PINS = 16,
  parameter int unsigned           DATA_W   = 32,
  parameter int unsigned           ADDR_W   = 3,
  parameter logic [NUM_PINS*4-1:0] RST_CFG  = 64'h8884_4444_4448_4444,
  parameter logic [NUM_PINS-1:0]   RST_ODR  = 16'hA010
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_req_i,
  input  logic                  bus_we_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  input  logic [DATA_W-1:0]     bus_wdata_i,
  output logic [DATA_W-1:0]     bus_rdata_o,
  input  logic [NUM_PINS-1:0]   af_out_i,
  input  logic [NUM_PINS-1:0]   pad_in_i,
  output logic [NUM_PINS-1:0]   pad_oe_o,
  output logic [NUM_PINS-1:0]   pad_out_o,
  output logic [NUM_PINS-1:0]   pad_pu_o,
  output logic [NUM_PINS-1:0]   pad_pd_o,
  output logic [NUM_PINS-1:0]   pad_ana_o,
  output logic [2*NUM_PINS-1:0] pad_slew_o
);
  logic [NUM_PINS*FIELD_W-1:0] cfg_w;
  logic [NUM_PINS-1:0]         odr_w, idr_w, in_en_w;

  gpio_regs #(
    .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .RST_CFG(RST_CFG), .RST_ODR(RST_ODR)
  ) regs_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (bus_req_i),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .idr_i   (idr_w),
    .rdata_o (bus_rdata_o),
    .cfg_o   (cfg_w),
    .odr_o   (odr_w)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    pad_ctl_t ctl;
    gpio_pin_decode dec_i (
      .field_i   (cfg_w[i*FIELD_W +: FIELD_W]),
      .odr_bit_i (odr_w[i]),
      .af_bit_i  (af_out_i[i]),
      .ctl_o     (ctl)
    );
    assign pad_oe_o[i]         = ctl.oe;
    assign pad_out_o[i]        = ctl.out;
    assign pad_pu_o[i]         = ctl.pu;
    assign pad_pd_o[i]         = ctl.pd;
    assign pad_ana_o[i]        = ctl.ana;
    assign pad_slew_o[2*i +: 2] = ctl.slew;
    assign in_en_w[i]          = ctl.in_en;
  end

  gpio_in_sample #(.NUM_PINS(NUM_PINS)) samp_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pad_in_i (pad_in_i),
    .in_en_i  (in_en_w),
    .idr_o    (idr_w)
  );
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int unsigned NUM_PINS = 16,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  bus_req_i,
  input logic                  bus_we_i,
  input logic [ADDR_W-1:0]     bus_addr_i,
  input logic [DATA_W-1:0]     bus_wdata_i,
  input logic [NUM_PINS-1:0]   pad_in_i,
  input logic [NUM_PINS-1:0]   pad_oe_o,
  input logic [NUM_PINS-1:0]   pad_out_o,
  input logic [NUM_PINS-1:0]   pad_pu_o,
  input logic [NUM_PINS-1:0]   pad_pd_o,
  input logic [NUM_PINS-1:0]   pad_ana_o,
  input logic [2*NUM_PINS-1:0] pad_slew_o,
  input logic [NUM_PINS*4-1:0] cfg_i,
  input logic [NUM_PINS-1:0]   odr_i,
  input logic [NUM_PINS-1:0]   idr_i
);
  localparam logic [ADDR_W-1:0] BSR_A = ADDR_W'(NUM_PINS * 4 / DATA_W + 2);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    logic [1:0] mode, cnf;
    assign mode = cfg_i[4*i +: 2];
    assign cnf  = cfg_i[4*i+2 +: 2];

    // R2
    ana_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pad_ana_o[i] |-> !(pad_oe_o[i] | pad_pu_o[i] | pad_pd_o[i]));

    // R4
    pull_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode == 2'b00 && cnf == 2'b10) |-> (pad_pu_o[i] == odr_i[i] && pad_pd_o[i] == !odr_i[i]));

    // R7
    od_no_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode != 2'b00 && cnf[0]) |-> !pad_out_o[i]);

    // R8
    in_slew_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode == 2'b00) |-> (pad_slew_o[2*i +: 2] == 2'b00));

    // R9
    idr_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (idr_i[i] == $past(pad_in_i[i] & ~pad_ana_o[i])));

    // R10
    bsr_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_req_i && bus_we_i && bus_addr_i == BSR_A && bus_wdata_i[i]) |=> odr_i[i]);
  end
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(
  .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_req_i   (bus_req_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .pad_in_i    (pad_in_i),
  .pad_oe_o    (pad_oe_o),
  .pad_out_o   (pad_out_o),
  .pad_pu_o    (pad_pu_o),
  .pad_pd_o    (pad_pd_o),
  .pad_ana_o   (pad_ana_o),
  .pad_slew_o  (pad_slew_o),
  .cfg_i       (cfg_w),
  .odr_i       (odr_w),
  .idr_i       (idr_w)
);

// File: tb/gpio_port_ctrl_tb_top.sv
module gpio_port_ctrl_tb_top;
  localparam int NP = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [2:0]    addr = '0;
  logic [31:0]   wdata = '0, rdata;
  logic [NP-1:0] af = '0, pad_in = '0;
  logic [NP-1:0] oe, po, pu, pd, ana;
  logic [2*NP-1:0] slew;

  always #4 clk = ~clk; // 125 MHz

  gpio_port_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .af_out_i(af), .pad_in_i(pad_in), .pad_oe_o(oe), .pad_out_o(po),
    .pad_pu_o(pu), .pad_pd_o(pd), .pad_ana_o(ana), .pad_slew_o(slew)
  );

  typedef struct { string req; logic [31:0] v; } item_t;
  item_t exp_q[$], act_q[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  // bench-side mirror of the programmed state
  logic [63:0]   m_cfg = 64'h8884_4444_4448_4444;
  logic [NP-1:0] m_odr = 16'hA010;

  task automatic expect_eq(string r, logic [31:0] act, logic [31:0] exp);
    exp_q.push_back('{r, exp});
    act_q.push_back('{r, act});
  endtask

  // monitor: pop and compare
  always @(posedge clk) begin
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      item_t a, e;
      a = act_q.pop_front();
      e = exp_q.pop_front();
      checks++;
      if (a.v !== e.v) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", e.req, a.v, e.v);
      end
    end
  end

  task automatic bus_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    #1;
  endtask

  task automatic bus_read(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic model(output logic [NP-1:0] e_oe, e_out, e_pu, e_pd, e_ana,
                       output logic [2*NP-1:0] e_slew);
    e_oe = '0; e_out = '0; e_pu = '0; e_pd = '0; e_ana = '0; e_slew = '0;
    for (int i = 0; i < NP; i++) begin
      logic [1:0] m, c;
      logic v;
      m = m_cfg[4*i +: 2];
      c = m_cfg[4*i+2 +: 2];
      if (m == 2'b00) begin
        if (c == 2'b00) e_ana[i] = 1'b1;
        else if (c == 2'b10) begin e_pu[i] = m_odr[i]; e_pd[i] = ~m_odr[i]; end
      end else begin
        e_slew[2*i +: 2] = m;
        v = c[1] ? af[i] : m_odr[i];
        if (c[0]) e_oe[i] = ~v;
        else begin e_oe[i] = 1'b1; e_out[i] = v; end
      end
    end
  endtask

  task automatic check_pads(string r);
    logic [NP-1:0] e_oe, e_out, e_pu, e_pd, e_ana;
    logic [2*NP-1:0] e_slew;
    model(e_oe, e_out, e_pu, e_pd, e_ana, e_slew);
    expect_eq({r, " oe"}, 32'(oe), 32'(e_oe));
    expect_eq({r, " out"}, 32'(po), 32'(e_out));
    expect_eq({r, " pu"}, 32'(pu), 32'(e_pu));
    expect_eq({r, " pd"}, 32'(pd), 32'(e_pd));
    expect_eq({r, " ana"}, 32'(ana), 32'(e_ana));
    expect_eq({r, " slew"}, slew, e_slew);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    expect_eq("R1 pu", 32'(pu), 32'h0000_A010);
    expect_eq("R1 pd", 32'(pd), 32'h0000_4000);
    expect_eq("R1 oe", 32'(oe), 32'h0);
    expect_eq("R1 ana", 32'(ana), 32'h0);
    bus_read(3'd0, d); expect_eq("R1 cfg lo", d, 32'h4448_4444);
    bus_read(3'd1, d); expect_eq("R1 cfg hi", d, 32'h8884_4444);
    bus_read(3'd3, d); expect_eq("R1 odr", d, 32'h0000_A010);

    // pins 0..7: analog, floating, pull, pull, gp pp, gp od, af pp, af od
    bus_write(3'd0, 32'hDB61_8840); m_cfg[31:0] = 32'hDB61_8840;
    bus_read(3'd0, d); expect_eq("R11 cfg lo readback", d, 32'hDB61_8840);
    bus_write(3'd3, 32'hFFFF_0004); m_odr = 16'h0004;
    bus_read(3'd3, d); expect_eq("R11 odr upper ignored", d, 32'h0000_0004);
    expect_eq("R2 analog pin0", 32'(ana[0]), 32'h1);
    expect_eq("R3 floating pin1", 32'({oe[1], pu[1], pd[1], ana[1]}), 32'h0);
    expect_eq("R4 pin2 up", 32'({pu[2], pd[2]}), 32'b10);
    expect_eq("R4 pin3 down", 32'({pu[3], pd[3]}), 32'b01);
    expect_eq("R5 pin4 pp low", 32'({oe[4], po[4]}), 32'b10);
    expect_eq("R7 pin5 od low drives", 32'({oe[5], po[5]}), 32'b10);
    expect_eq("R8 pin5 slew", 32'(slew[11:10]), 32'h2);
    check_pads("R2/R3/R4/R5/R7/R8 low word");

    // R10 set/clear: set 4,5; clear 2,4 -> set wins on pin 4
    bus_write(3'd4, 32'h0014_0030); m_odr = (m_odr & ~16'h0014) | 16'h0030;
    bus_read(3'd3, d); expect_eq("R10 set wins", d, 32'h0000_0030);
    bus_read(3'd4, d); expect_eq("R10 reads zero", d, 32'h0);
    expect_eq("R7 pin5 od high released", 32'({oe[5], po[5]}), 32'b00);
    expect_eq("R4 pin2 now down", 32'({pu[2], pd[2]}), 32'b01);
    check_pads("R10 pads after set/clear");

    // R6 alternate-function values
    @(negedge clk); af = 16'h00C0; #1;
    expect_eq("R6 pin6 af high", 32'({oe[6], po[6]}), 32'b11);
    expect_eq("R6 R7 pin7 af od released", 32'({oe[7], po[7]}), 32'b00);
    check_pads("R6 af=00C0");
    @(negedge clk); af = 16'h0000; #1;
    expect_eq("R6 R7 pin7 af od low", 32'({oe[7], po[7]}), 32'b10);
    check_pads("R6 af=0000");

    // R9 input sampling with pin0 analog
    @(negedge clk); pad_in = 16'hFFFF;
    bus_read(3'd2, d); expect_eq("R9 idr masks analog", d, 32'h0000_FFFE);
    bus_write(3'd2, 32'h0000_0000);
    bus_read(3'd2, d); expect_eq("R9 idr write ignored", d, 32'h0000_FFFE);
    bus_read(3'd3, d); expect_eq("R9 odr untouched", d, 32'h0000_0030);

    // pins 8..15: gp od 50, analog, af pp 2, float x4, pull
    bus_write(3'd1, 32'h8444_4A07); m_cfg[63:32] = 32'h8444_4A07;
    bus_read(3'd1, d); expect_eq("R11 cfg hi readback", d, 32'h8444_4A07);
    expect_eq("R8 pin8 slew", 32'(slew[17:16]), 32'h3);
    expect_eq("R8 pin10 slew", 32'(slew[21:20]), 32'h2);
    check_pads("R2/R6/R7/R8 high word");
    @(negedge clk); pad_in = 16'h5A5A;
    bus_read(3'd2, d); expect_eq("R9 R2 idr second pattern", d, 32'h0000_585A);

    repeat (4) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule